// File: doc/BRIEF.md
# Two-Word Instruction Buffer Access Port

This block holds a 128-entry buffer that a host processor fills and inspects through one 16-bit data port. Every entry pairs a 16-bit word with an 8-bit flag group. Entries 0x00 to 0x3F form the instruction region and entries 0x40 to 0x7F form the data region. Both regions sit behind one 7-bit address pointer, so a run of host accesses moves from one region into the other without a gap.

The host uses two registers. The buffer port reaches the entry the pointer selects. The first access to an entry moves its 16-bit word and the second access moves its flag group. The pointer steps forward only after that second access. The control register shows the pointer and a phase bit, and a write to it moves the pointer to a new entry. A separate sequencer port reads any entry combinationally by its own address and leaves the host pointer and phase alone.

Top module: `ibuf_access_port`

## Requirements
- R1: After a synchronous reset the pointer is 0x00 and the phase bit is 0, so a control-register read returns 0x0000.
- R2: With the phase bit at 0, a buffer-port access moves the entry's 16-bit word. With the phase bit at 1, it moves the flag group in data bits 7:0: bit 7 write flag, bit 6 compare flag, bit 5 compare-enable flag, bit 4 special flag, bit 3 select bit, bits 2:0 level field.
- R3: Bits 15:8 of a second-phase read always return zero, whatever was written in them.
- R4: A first-phase buffer access sets the phase bit and leaves the pointer unchanged. A second-phase access clears the phase bit and adds one to the pointer.
- R5: Reads of the buffer port move the phase bit and the pointer exactly as writes do.
- R6: A control-register write loads the pointer from data bits 6:0 and clears the phase bit. A control-register read returns the pointer in bits 6:0 and the phase bit in bit 15, with all other bits zero. Control-register accesses never touch buffer contents.
- R7: The pointer wraps from 0x7F to 0x00.
- R8: The sequencer port returns the word and the flag group stored at its address in the same cycle, and has no effect on the pointer, the phase bit or the contents.
- R9: The region output is 0 while the pointer is in 0x00 to 0x3F and 1 while it is in 0x40 to 0x7F. Stepping from 0x3F goes straight to 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_acc | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ctl | input | 1 | 1 = control register, 0 = buffer port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the register addressed this cycle |
| host_region | output | 1 | Region of the entry the pointer selects (0 instruction, 1 data) |
| seq_addr | input | 7 | Sequencer read address |
| seq_word | output | 16 | Word stored at seq_addr |
| seq_flags | output | 8 | Flag group stored at seq_addr |

## Verification
The assertions assume that host_acc, host_wr and host_ctl hold known values in every cycle after reset. They also assume that host_acc is low during reset, because the checks that compare stored contents against the previous cycle's write data rely on it. The bench drives every input at the falling edge and keeps the strobe low through reset. It makes at most one access per cycle and reads back only entries it has written, so the undefined contents after reset never reach a compared value.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int FLAG_W  = 8;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAD_W   = DATA_W - FLAG_W;

    // Flag group layout: bit 7 down to bit 0
    typedef struct packed {
        logic       wr_f;
        logic       cmp_f;
        logic       ecmp_f;
        logic       spc_f;
        logic       sel_f;
        logic [2:0] lvl;
    } flag_t;

    typedef enum logic {
        PH_WORD = 1'b0,
        PH_FLAG = 1'b1
    } phase_e;

    typedef struct packed {
        logic              acc;
        logic              wr;
        logic              ctl;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    function automatic flag_t to_flags(input logic [DATA_W-1:0] d);
        return flag_t'(d[FLAG_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] flags_to_word(input flag_t f);
        return {{PAD_W{1'b0}}, f};
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(input logic [ADDR_W-1:0] p,
                                                   input phase_e ph);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ADDR_W-1:0] = p;
        w[DATA_W-1]   = (ph == PH_FLAG);
        return w;
    endfunction
endpackage

// File: rtl/ibuf_ptr_ctrl.sv
module ibuf_ptr_ctrl
    import ibuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    output logic [ADDR_W-1:0] ptr,
    output phase_e            phase,
    output logic              word_we,
    output logic              flag_we
);
    logic buf_acc;
    logic ctl_ld;

    assign buf_acc = req.acc && !req.ctl;
    assign ctl_ld  = req.acc && req.ctl && req.wr;
    assign word_we = buf_acc && req.wr && (phase == PH_WORD);
    assign flag_we = buf_acc && req.wr && (phase == PH_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            phase <= PH_WORD;
        end else if (ctl_ld) begin
            ptr   <= req.wdata[ADDR_W-1:0];
            phase <= PH_WORD;
        end else if (buf_acc) begin
            if (phase == PH_FLAG) begin
                ptr   <= ptr + 1'b1;
                phase <= PH_WORD;
            end else begin
                phase <= PH_FLAG;
            end
        end
    end

    // R4
    first_phase_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (req.acc && !req.ctl && phase == PH_WORD) |=> (phase == PH_FLAG && $stable(ptr)));

    // R4
    second_phase_steps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (req.acc && !req.ctl && phase == PH_FLAG) |=>
            (phase == PH_WORD && ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R6
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req.acc && req.ctl && req.wr) |=>
            (phase == PH_WORD && ptr == $past(req.wdata[ADDR_W-1:0])));

    // R8
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.acc || (req.ctl && !req.wr)) |=> ($stable(ptr) && $stable(phase)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (req.acc && !req.ctl && phase == PH_FLAG && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              word_we,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_word,
    output flag_t             rd_a_flags,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_word,
    output flag_t             rd_b_flags
);
    logic [DATA_W-1:0] word_mem [DEPTH];
    flag_t             flag_mem [DEPTH];

    // Contents are not reset; only the pointer state is.
    always_ff @(posedge clk) begin
        if (word_we)
            word_mem[wr_addr] <= wdata;
        if (flag_we)
            flag_mem[wr_addr] <= to_flags(wdata);
    end

    assign rd_a_word  = word_mem[rd_a_addr];
    assign rd_a_flags = flag_mem[rd_a_addr];
    assign rd_b_word  = word_mem[rd_b_addr];
    assign rd_b_flags = flag_mem[rd_b_addr];

    // R2
    word_store_chk: assert property (@(posedge clk) disable iff (rst)
        word_we |=> (word_mem[$past(wr_addr)] == $past(wdata)));

    // R2
    flag_store_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_mem[$past(wr_addr)] == $past(wdata[FLAG_W-1:0])));

    // R2
    one_field_chk: assert property (@(posedge clk) disable iff (rst)
        !(word_we && flag_we));
endmodule

// File: rtl/ibuf_host_mux.sv
module ibuf_host_mux
    import ibuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_sel,
    input  logic [ADDR_W-1:0] ptr,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] cur_word,
    input  flag_t             cur_flags,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        if (ctl_sel)
            rdata = ctl_word(ptr, phase);
        else if (phase == PH_FLAG)
            rdata = flags_to_word(cur_flags);
        else
            rdata = cur_word;
    end

    // R3
    flag_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_sel && phase == PH_FLAG) |-> (rdata[DATA_W-1:FLAG_W] == '0));

    // R6
    ctl_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_sel |-> (rdata[DATA_W-2:ADDR_W] == '0));
endmodule

// File: rtl/ibuf_access_port.sv
module ibuf_access_port
    import ibuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_acc,
    input  logic        host_wr,
    input  logic        host_ctl,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_region,
    input  logic [6:0]  seq_addr,
    output logic [15:0] seq_word,
    output logic [7:0]  seq_flags
);
    host_req_t         req;
    logic [ADDR_W-1:0] ptr;
    phase_e            phase;
    logic              word_we;
    logic              flag_we;
    logic [DATA_W-1:0] cur_word;
    flag_t             cur_flags;
    flag_t             sq_flags;

    assign req = '{acc: host_acc, wr: host_wr, ctl: host_ctl, wdata: host_wdata};

    ibuf_ptr_ctrl u_ptr (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ptr     (ptr),
        .phase   (phase),
        .word_we (word_we),
        .flag_we (flag_we)
    );

    ibuf_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_addr    (ptr),
        .word_we    (word_we),
        .flag_we    (flag_we),
        .wdata      (host_wdata),
        .rd_a_addr  (ptr),
        .rd_a_word  (cur_word),
        .rd_a_flags (cur_flags),
        .rd_b_addr  (seq_addr),
        .rd_b_word  (seq_word),
        .rd_b_flags (sq_flags)
    );

    ibuf_host_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .ctl_sel   (host_ctl),
        .ptr       (ptr),
        .phase     (phase),
        .cur_word  (cur_word),
        .cur_flags (cur_flags),
        .rdata     (host_rdata)
    );

    assign seq_flags   = sq_flags;
    assign host_region = ptr[ADDR_W-1];

    // R9
    region_step_chk: assert property (@(posedge clk) disable iff (rst)
        (host_acc && !host_ctl && phase == PH_FLAG && ptr == 7'h3F) |=> host_region);
endmodule

// File: tb/tb_ibuf_access_port.sv
module tb_ibuf_access_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_acc, host_wr, host_ctl;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        host_region;
    logic [6:0]  seq_addr;
    logic [15:0] seq_word;
    logic [7:0]  seq_flags;

    int vectors = 0;
    int miscompares = 0;
    logic [15:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibuf_access_port dut (
        .clk(clk), .rst(rst), .host_acc(host_acc), .host_wr(host_wr),
        .host_ctl(host_ctl), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_region(host_region), .seq_addr(seq_addr), .seq_word(seq_word),
        .seq_flags(seq_flags)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one host access; read data sampled mid-cycle, before the edge that acts on it
    task automatic host_op(input logic wr, input logic ctl, input logic [15:0] d,
                           output logic [15:0] r);
        @(negedge clk);
        host_acc = 1'b1; host_wr = wr; host_ctl = ctl; host_wdata = d;
        #(CLK_PERIOD/4);
        r = host_rdata;
        @(negedge clk);
        host_acc = 1'b0; host_wr = 1'b0; host_ctl = 1'b0;
    endtask

    task automatic ctl_read(output logic [15:0] r);
        @(negedge clk);
        host_ctl = 1'b1;
        #(CLK_PERIOD/4);
        r = host_rdata;
        host_ctl = 1'b0;
    endtask

    task automatic load_ptr(input logic [6:0] p);
        logic [15:0] r;
        host_op(1'b1, 1'b1, {9'h1FF, p}, r);
    endtask

    task automatic write_entry(input logic [15:0] w, input logic [15:0] f);
        logic [15:0] r;
        host_op(1'b1, 1'b0, w, r);
        host_op(1'b1, 1'b0, f, r);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        ctl_read(rd);
        check("R1 ctl after reset", rd, 16'h0000);
        check("R9 region after reset", {15'b0, host_region}, 16'h0);
    endtask

    task automatic t_write_read;
        load_ptr(7'h10);
        host_op(1'b1, 1'b0, 16'hBEEF, rd);
        ctl_read(rd);
        check("R4 after first phase", rd, 16'h8010);
        host_op(1'b1, 1'b0, 16'hFFA5, rd);
        ctl_read(rd);
        check("R4 after second phase", rd, 16'h0011);
        load_ptr(7'h10);
        host_op(1'b0, 1'b0, 16'h0, rd);
        check("R2 word readback", rd, 16'hBEEF);
        host_op(1'b0, 1'b0, 16'h0, rd);
        check("R3 flag readback upper zero", rd, 16'h00A5);
        ctl_read(rd);
        check("R5 read pair advances", rd, 16'h0011);
    endtask

    task automatic t_flag_fields;
        load_ptr(7'h20);
        write_entry(16'h1234, 16'h0089);
        seq_addr = 7'h20;
        #1;
        check("R2 write flag bit7", {15'b0, seq_flags[7]}, 16'h1);
        check("R2 level field bits2:0", {13'b0, seq_flags[2:0]}, 16'h1);
        check("R2 select bit3", {15'b0, seq_flags[3]}, 16'h1);
    endtask

    task automatic t_phase_reset;
        load_ptr(7'h30);
        host_op(1'b1, 1'b0, 16'h5555, rd);
        load_ptr(7'h31);
        ctl_read(rd);
        check("R6 load clears phase", rd, 16'h0031);
        host_op(1'b1, 1'b0, 16'h6666, rd);
        seq_addr = 7'h31;
        #1;
        check("R6 first word after load", seq_word, 16'h6666);
        seq_addr = 7'h30;
        #1;
        check("R6 ctl write leaves contents", seq_word, 16'h5555);
    endtask

    task automatic t_wrap_region;
        load_ptr(7'h3F);
        check("R9 region at 0x3F", {15'b0, host_region}, 16'h0);
        write_entry(16'hAAAA, 16'h0011);
        ctl_read(rd);
        check("R9 step into data region", rd, 16'h0040);
        check("R9 region at 0x40", {15'b0, host_region}, 16'h1);
        load_ptr(7'h7F);
        write_entry(16'hC0DE, 16'h0042);
        ctl_read(rd);
        check("R7 wrap to zero", rd, 16'h0000);
        seq_addr = 7'h7F;
        #1;
        check("R8 seq word 0x7F", seq_word, 16'hC0DE);
        check("R8 seq flags 0x7F", {8'h0, seq_flags}, 16'h0042);
    endtask

    task automatic t_seq_isolation;
        load_ptr(7'h50);
        host_op(1'b1, 1'b0, 16'h7777, rd);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seq_addr = 7'(i * 17);
        end
        ctl_read(rd);
        check("R8 seq leaves ptr and phase", rd, 16'h8050);
        host_op(1'b1, 1'b0, 16'h00FF, rd);
        seq_addr = 7'h50;
        #1;
        check("R8 seq word 0x50", seq_word, 16'h7777);
        check("R8 seq flags 0x50", {8'h0, seq_flags}, 16'h00FF);
    endtask

    initial begin
        rst = 1'b1; host_acc = 1'b0; host_wr = 1'b0; host_ctl = 1'b0;
        host_wdata = '0; seq_addr = '0;
        t_reset();
        t_write_read();
        t_flag_fields();
        t_phase_reset();
        t_wrap_region();
        t_seq_isolation();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule